// File: doc/BRIEF.md
# Hypervisor-Aware Local Interrupt Selector

This block sits beside the trap logic of a hart that supports virtualization. Each cycle it looks at the local interrupt pending and enable vectors, at the two delegation masks (machine-to-supervisor and hypervisor-to-guest), at the current privilege level and virtualization flag, and at the machine and supervisor global interrupt-enable bits. From these it decides whether an interrupt must be taken, which cause number wins, and whether the machine level, the hypervisor-supervisor (HS) level or the virtual-supervisor (VS) level must handle it.

Every enabled interrupt is routed into one of three gating groups by the two masks, and each group has its own global enable. Guest-level causes are not filtered out ahead of routing, so they reach HS or machine handlers whenever they are not delegated to the guest. HS interrupts stay enabled for as long as the hart is virtualized, because HS ranks above VS. The decision is captured in one output register, so the outputs reflect the inputs sampled at the previous rising clock edge.

Top module: `irqsel_top`

## Requirements
- R1: A bit is a candidate only when it is set in both the pending and the enable vector; a bit set in only one of them is never taken.
- R2: Machine-group bits (clear in the machine delegation mask) are enabled when the privilege code is numerically below 3 (U=0, S=1, M=3), or when it is 3 and the machine global enable is set.
- R3: HS-group bits (set in the machine mask, clear in the hypervisor mask) are enabled when the supervisor-level enable holds or the virtualization flag is set; the supervisor-level enable holds when the privilege is 0, or is 1 with the supervisor global enable set.
- R4: VS-group bits (set in both masks) are enabled only when both the supervisor-level enable and the virtualization flag hold.
- R5: A winning bit from the machine group reports handler code 3 (M).
- R6: A winning bit from the HS group reports handler code 1 (HS).
- R7: A winning bit from the VS group reports handler code 2 (VS).
- R8: Among all enabled candidates of all groups, the lowest-numbered bit wins, whatever its group.
- R9: When no candidate is enabled, the take flag is 0, the cause is 0 and the handler code is 0.
- R10: Outputs change only at a rising clock edge, reflecting the inputs sampled at that edge; while reset is asserted all outputs are 0.
- R11: Guest causes 2, 6 and 10 (software, timer, external) are routed to the HS or machine handler when not delegated to the guest, also while the virtualization flag is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_vec | input | 64 | Pending interrupt bits |
| enab_vec | input | 64 | Per-cause enable bits |
| mdeleg_mask | input | 64 | Machine-to-supervisor delegation mask |
| hdeleg_mask | input | 64 | Hypervisor-to-guest delegation mask |
| cur_priv | input | 2 | Current privilege (U=0, S=1, M=3) |
| virt_on | input | 1 | Hart is running a guest |
| m_gie | input | 1 | Machine global interrupt enable |
| s_gie | input | 1 | Supervisor global interrupt enable |
| irq_take | output | 1 | An interrupt must be taken |
| irq_cause | output | 6 | Winning cause number |
| irq_target | output | 2 | Handler level: 0 none, 1 HS, 2 VS, 3 M |

## Verification
A wrong group enable or a swapped mask test shows at the ports one cycle after the input change, either as a missed take, an interrupt taken at the wrong privilege, or a handler code that disagrees with the masks at the winning bit. A broken priority chain shows as a cause number above some other enabled candidate, also after a single cycle. Directed cases hit each gating group with the global enables on and off at each privilege, and a pseudo-random sweep compares every cycle against an independently written model.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_HS   = 2'd1,
    TGT_VS   = 2'd2,
    TGT_M    = 2'd3
  } irq_tgt_e;

  // Level enable: privilege strictly below the level, or at the level with
  // that level's global enable set.
  function automatic logic level_open(input logic [1:0] priv,
                                      input logic [1:0] level,
                                      input logic       gie);
    return (priv < level) || ((priv == level) && gie);
  endfunction

  function automatic logic hs_open(input logic s_lvl, input logic virt);
    return s_lvl || virt;
  endfunction

  function automatic logic vs_open(input logic s_lvl, input logic virt);
    return s_lvl && virt;
  endfunction

endpackage

// File: rtl/irqsel_gate.sv
module irqsel_gate
  import irqsel_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] cand,
  input  logic [XLEN-1:0] mdel,
  input  logic [XLEN-1:0] hdel,
  input  logic [1:0]      priv,
  input  logic            virt,
  input  logic            mgie,
  input  logic            sgie,
  output logic [XLEN-1:0] m_grp,
  output logic [XLEN-1:0] hs_grp,
  output logic [XLEN-1:0] vs_grp
);

  logic m_en;
  logic s_en;
  logic hs_en;
  logic vs_en;

  assign m_en  = level_open(priv, PRIV_M, mgie);
  assign s_en  = level_open(priv, PRIV_S, sgie);
  assign hs_en = hs_open(s_en, virt);
  assign vs_en = vs_open(s_en, virt);

  assign m_grp  = cand & ~mdel &         {XLEN{m_en}};
  assign hs_grp = cand &  mdel & ~hdel & {XLEN{hs_en}};
  assign vs_grp = cand &  mdel &  hdel & {XLEN{vs_en}};

endmodule

// File: rtl/irqsel_pick.sv
module irqsel_pick #(
  parameter int XLEN = 64,
  localparam int IDXW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] vec,
  output logic            hit,
  output logic [XLEN-1:0] first,
  output logic [IDXW-1:0] idx
);

  // seen[i] is set when any bit below i is set
  logic [XLEN-1:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < XLEN; i++) begin : g_chain
    if (i < XLEN - 1) begin : g_link
      assign seen[i+1] = seen[i] | vec[i];
    end
    assign first[i] = vec[i] & ~seen[i];
  end

  assign hit = |vec;

  always_comb begin
    idx = '0;
    for (int i = 0; i < XLEN; i++) begin
      if (first[i]) idx = idx | IDXW'(i);
    end
  end

endmodule

// File: rtl/irqsel_top.sv
module irqsel_top
  import irqsel_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int IDXW = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] pend_vec,
  input  logic [XLEN-1:0] enab_vec,
  input  logic [XLEN-1:0] mdeleg_mask,
  input  logic [XLEN-1:0] hdeleg_mask,
  input  logic [1:0]      cur_priv,
  input  logic            virt_on,
  input  logic            m_gie,
  input  logic            s_gie,
  output logic            irq_take,
  output logic [IDXW-1:0] irq_cause,
  output logic [1:0]      irq_target
);

  logic [XLEN-1:0] cand_vec;
  logic [XLEN-1:0] m_grp;
  logic [XLEN-1:0] hs_grp;
  logic [XLEN-1:0] vs_grp;
  logic [XLEN-1:0] gated_all;
  logic [XLEN-1:0] win_onehot;
  logic            win_hit;
  logic [IDXW-1:0] win_idx;
  irq_tgt_e        win_tgt;

  assign cand_vec = pend_vec & enab_vec;

  irqsel_gate #(.XLEN(XLEN)) u_gate (
    .cand   (cand_vec),
    .mdel   (mdeleg_mask),
    .hdel   (hdeleg_mask),
    .priv   (cur_priv),
    .virt   (virt_on),
    .mgie   (m_gie),
    .sgie   (s_gie),
    .m_grp  (m_grp),
    .hs_grp (hs_grp),
    .vs_grp (vs_grp)
  );

  assign gated_all = m_grp | hs_grp | vs_grp;

  irqsel_pick #(.XLEN(XLEN)) u_pick (
    .vec   (gated_all),
    .hit   (win_hit),
    .first (win_onehot),
    .idx   (win_idx)
  );

  always_comb begin
    if (|(win_onehot & m_grp))       win_tgt = TGT_M;
    else if (|(win_onehot & hs_grp)) win_tgt = TGT_HS;
    else if (|(win_onehot & vs_grp)) win_tgt = TGT_VS;
    else                             win_tgt = TGT_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_take   <= 1'b0;
      irq_cause  <= '0;
      irq_target <= TGT_NONE;
    end else begin
      irq_take   <= win_hit;
      irq_cause  <= win_hit ? win_idx : '0;
      irq_target <= win_tgt;
    end
  end

endmodule

// File: rtl/irqsel_chk.sv
module irqsel_chk #(
  parameter int XLEN = 64,
  localparam int IDXW = $clog2(XLEN)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [XLEN-1:0] cand_vec,
  input logic [XLEN-1:0] mdeleg_mask,
  input logic [XLEN-1:0] hdeleg_mask,
  input logic [XLEN-1:0] gated_all,
  input logic [1:0]      cur_priv,
  input logic            virt_on,
  input logic            m_gie,
  input logic            irq_take,
  input logic [IDXW-1:0] irq_cause,
  input logic [1:0]      irq_target
);

  logic [XLEN-1:0] prev_cand;
  logic [XLEN-1:0] prev_mdel;
  logic [XLEN-1:0] prev_hdel;
  logic [XLEN-1:0] prev_gated;
  logic [1:0]      prev_priv;
  logic            prev_virt;
  logic            prev_mgie;
  logic [XLEN-1:0] below_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_cand  <= '0;
      prev_mdel  <= '0;
      prev_hdel  <= '0;
      prev_gated <= '0;
      prev_priv  <= '0;
      prev_virt  <= 1'b0;
      prev_mgie  <= 1'b0;
    end else begin
      prev_cand  <= cand_vec;
      prev_mdel  <= mdeleg_mask;
      prev_hdel  <= hdeleg_mask;
      prev_gated <= gated_all;
      prev_priv  <= cur_priv;
      prev_virt  <= virt_on;
      prev_mgie  <= m_gie;
    end
  end

  assign below_mask = (XLEN'(1) << irq_cause) - XLEN'(1);

  AST_TAKE_IS_CANDIDATE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> prev_cand[irq_cause]); // R1

  AST_M_LOCKED_AT_M: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && prev_priv == 2'd3 && !prev_mgie) |-> irq_target != 2'd3); // R2

  AST_VS_NEEDS_GUEST: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_target == 2'd2) |-> prev_virt); // R4

  AST_ROUTE_M: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && irq_target == 2'd3) |-> !prev_mdel[irq_cause]); // R5

  AST_ROUTE_HS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && irq_target == 2'd1) |-> (prev_mdel[irq_cause] && !prev_hdel[irq_cause])); // R6

  AST_ROUTE_VS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && irq_target == 2'd2) |-> (prev_mdel[irq_cause] && prev_hdel[irq_cause])); // R7

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (prev_gated[irq_cause] && ((prev_gated & below_mask) == '0))); // R8

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_take |-> (irq_cause == '0 && irq_target == 2'd0)); // R9

  AST_TAKE_TRACKS_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take == (prev_gated != '0)); // R10

endmodule

bind irqsel_top irqsel_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cand_vec    (cand_vec),
  .mdeleg_mask (mdeleg_mask),
  .hdeleg_mask (hdeleg_mask),
  .gated_all   (gated_all),
  .cur_priv    (cur_priv),
  .virt_on     (virt_on),
  .m_gie       (m_gie),
  .irq_take    (irq_take),
  .irq_cause   (irq_cause),
  .irq_target  (irq_target)
);

// File: tb/sim_irqsel_top.sv
module sim_irqsel_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] pend_vec = '0;
  logic [63:0] enab_vec = '0;
  logic [63:0] mdeleg_mask = '0;
  logic [63:0] hdeleg_mask = '0;
  logic [1:0]  cur_priv = 2'd0;
  logic        virt_on = 1'b0;
  logic        m_gie = 1'b0;
  logic        s_gie = 1'b0;
  logic        irq_take;
  logic [5:0]  irq_cause;
  logic [1:0]  irq_target;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqsel_top u0 (
    .clk, .rst_n, .pend_vec, .enab_vec, .mdeleg_mask, .hdeleg_mask,
    .cur_priv, .virt_on, .m_gie, .s_gie, .irq_take, .irq_cause, .irq_target
  );

  task automatic compare(input string req, input logic etk,
                         input int ecause, input int etgt);
    logic [8:0] got, exp;
    got = {irq_take, irq_cause, irq_target};
    exp = {etk, 6'(ecause), 2'(etgt)};
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got take=%0b cause=%0d tgt=%0d, expected take=%0b cause=%0d tgt=%0d",
               req, irq_take, irq_cause, irq_target, etk, ecause, etgt);
    end
  endtask

  // Inputs are set at a falling edge; the register captures at the next
  // rising edge; results are read at the following falling edge.
  task automatic step_check(input string req, input logic etk,
                            input int ecause, input int etgt);
    @(posedge clk);
    @(negedge clk);
    compare(req, etk, ecause, etgt);
  endtask

  task automatic setup(input logic [63:0] p, input logic [63:0] e,
                       input logic [63:0] md, input logic [63:0] hd,
                       input logic [1:0] pr, input logic v,
                       input logic mg, input logic sg);
    pend_vec = p; enab_vec = e; mdeleg_mask = md; hdeleg_mask = hd;
    cur_priv = pr; virt_on = v; m_gie = mg; s_gie = sg;
  endtask

  // Independent model: scan from the top so the last accepted bit is the lowest.
  task automatic model(output logic tk, output int c, output int t);
    logic ml, sl, ok;
    int grp;
    ml = (cur_priv != 2'd3) || m_gie;
    sl = (cur_priv == 2'd0) || (cur_priv == 2'd1 && s_gie);
    tk = 1'b0; c = 0; t = 0;
    for (int b = 63; b >= 0; b--) begin
      if (!mdeleg_mask[b])      begin grp = 3; ok = ml; end
      else if (!hdeleg_mask[b]) begin grp = 1; ok = sl | virt_on; end
      else                      begin grp = 2; ok = sl & virt_on; end
      if (pend_vec[b] && enab_vec[b] && ok) begin
        tk = 1'b1; c = b; t = grp;
      end
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    setup(64'h80, 64'h80, 64'h0, 64'h0, 2'd0, 1'b0, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    compare("R10 reset", 1'b0, 0, 0);
    rst_n = 1'b1;
    step_check("R10 first capture", 1'b1, 7, 3);
  endtask

  task automatic t_candidate;
    setup(64'h8, 64'h0, 64'h0, 64'h0, 2'd0, 1'b0, 1'b1, 1'b1);
    step_check("R1 pending only", 1'b0, 0, 0);
    setup(64'h0, 64'h8, 64'h0, 64'h0, 2'd0, 1'b0, 1'b1, 1'b1);
    step_check("R1 enabled only", 1'b0, 0, 0);
  endtask

  task automatic t_machine;
    setup(64'h80, 64'h80, 64'h0, 64'h0, 2'd3, 1'b0, 1'b0, 1'b1);
    step_check("R2 M with gie off", 1'b0, 0, 0);
    m_gie = 1'b1;
    step_check("R5 M with gie on", 1'b1, 7, 3);
    setup(64'h800, 64'h800, 64'h0, 64'h0, 2'd1, 1'b0, 1'b0, 1'b0);
    step_check("R2 below M ignores gie", 1'b1, 11, 3);
  endtask

  task automatic t_hs;
    setup(64'h20, 64'h20, 64'h20, 64'h0, 2'd1, 1'b0, 1'b1, 1'b0);
    step_check("R3 HS at S gie off", 1'b0, 0, 0);
    virt_on = 1'b1;
    step_check("R3 HS forced open by guest", 1'b1, 5, 1);
    virt_on = 1'b0; cur_priv = 2'd0;
    step_check("R6 HS from U", 1'b1, 5, 1);
    cur_priv = 2'd3;
    step_check("R3 HS closed at M", 1'b0, 0, 0);
  endtask

  task automatic t_vs;
    setup(64'h40, 64'h40, 64'h40, 64'h40, 2'd1, 1'b0, 1'b1, 1'b1);
    step_check("R4 VS without guest", 1'b0, 0, 0);
    virt_on = 1'b1;
    step_check("R7 VS in guest S gie on", 1'b1, 6, 2);
    s_gie = 1'b0;
    step_check("R4 VS in guest S gie off", 1'b0, 0, 0);
    cur_priv = 2'd0;
    step_check("R7 VS in guest U", 1'b1, 6, 2);
  endtask

  task automatic t_guest_causes;
    setup(64'h400, 64'h400, 64'h400, 64'h0, 2'd0, 1'b0, 1'b0, 1'b0);
    step_check("R11 cause 10 to HS unvirtualized", 1'b1, 10, 1);
    setup(64'h4, 64'h4, 64'h0, 64'h0, 2'd1, 1'b0, 1'b0, 1'b0);
    step_check("R11 cause 2 to M unvirtualized", 1'b1, 2, 3);
    setup(64'h40, 64'h40, 64'h40, 64'h0, 2'd1, 1'b1, 1'b0, 1'b0);
    step_check("R11 cause 6 to HS in guest", 1'b1, 6, 1);
  endtask

  task automatic t_priority;
    // bit 1 HS (closed), bits 9 and 12 M (open)
    setup(64'h1202, 64'h1202, 64'h2, 64'h0, 2'd1, 1'b0, 1'b0, 1'b0);
    step_check("R8 skip closed lower bit", 1'b1, 9, 3);
    // bit 2 VS (open in guest U), bit 7 M
    setup(64'h84, 64'h84, 64'h4, 64'h4, 2'd0, 1'b1, 1'b0, 1'b0);
    step_check("R8 VS beats higher M", 1'b1, 2, 2);
    setup(64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0,
          2'd0, 1'b0, 1'b0, 1'b0);
    step_check("R8 top bit alone", 1'b1, 63, 3);
  endtask

  task automatic t_idle;
    setup(64'hFFFF, 64'hFFFF, 64'hFFFF, 64'hFFFF, 2'd3, 1'b0, 1'b0, 1'b1);
    step_check("R9 nothing open", 1'b0, 0, 0);
  endtask

  task automatic t_sweep;
    logic [63:0] s;
    logic etk;
    int ec, et;
    s = 64'h9E37_79B9_7F4A_7C15;
    for (int k = 0; k < 300; k++) begin
      s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
      pend_vec = s;
      s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
      enab_vec = s & {s[31:0], s[63:32]};
      s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
      mdeleg_mask = s;
      hdeleg_mask = {s[40:0], s[63:41]};
      cur_priv = s[1:0]; virt_on = s[2]; m_gie = s[3]; s_gie = s[4];
      model(etk, ec, et);
      step_check("R8 sweep", etk, ec, et);
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_candidate();
    t_machine();
    t_hs();
    t_vs();
    t_guest_causes();
    t_priority();
    t_idle();
    t_sweep();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got no finish, expected end of run");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule